// File: doc/BRIEF.md
# A/D Conversion Phase Timer

This block generates the timing skeleton of a single analog-to-digital conversion, measured in peripheral clock cycles. When a start request arrives with a channel number, it first raises a sample phase and then a compare phase. When the compare phase ends, it emits a one-cycle done pulse. The analog front end and the successive-approximation logic follow these phase signals. Neither of them is part of this block.

The length of the sample phase comes from one of two sampling setups. Each setup has a 6-bit count and a 2-bit scaling code. A 32-bit select word holds one bit per channel and chooses which setup the requested channel uses. The length of the compare phase comes from a 3-bit compare setting. All settings are captured when a start is accepted, so each conversion runs with the values that were present at its start.

Top module: `adc_phase_timer`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, sample_ph, compare_ph and done are all 0.
- R2: A start is accepted on a clock edge at which busy is 0. sample_ph rises in the cycle after acceptance and stays high for (N+1)*K cycles. N is the chosen setup's count and K is set by its scaling code: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 16.
- R3: When the scaling code is 00, a count below 3 is treated as 3, which gives 4 cycles. When the code is 01, 10 or 11, the count is used unchanged, so a count of 0 with code 01 gives 4 cycles.
- R4: Bit `chan` of ch_setup_sel chooses the setup. A value of 0 selects setup 0 (st0_cnt, st0_mul) and a value of 1 selects setup 1 (st1_cnt, st1_mul). This holds for every channel from 0 to 31.
- R5: compare_ph rises in the cycle right after the last sample cycle and stays high for (C+1)*10+4 cycles, where C is cmp_ct. For example, C=1 gives 24 cycles and C=7 gives 84.
- R6: done is high for exactly one cycle, directly after the last compare cycle. busy is high from the first sample cycle through the done cycle, and is 0 in the cycle after done.
- R7: A start that arrives while busy is 1 is ignored. The conversion in progress keeps its phase lengths, and no extra conversion follows it.
- R8: Changes to the setups, the select word, cmp_ct or chan while busy is 1 do not change the running conversion.
- R9: At most one of sample_ph, compare_ph and done is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion start request |
| chan | input | 5 | Channel number of the request |
| st0_cnt | input | 6 | Sampling count, setup 0 |
| st0_mul | input | 2 | Scaling code, setup 0 |
| st1_cnt | input | 6 | Sampling count, setup 1 |
| st1_mul | input | 2 | Scaling code, setup 1 |
| ch_setup_sel | input | 32 | Per-channel setup select bit |
| cmp_ct | input | 3 | Compare-time setting |
| busy | output | 1 | Conversion in progress |
| sample_ph | output | 1 | Sample phase active |
| compare_ph | output | 1 | Compare phase active |
| done | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The bench drives the corner cases of the sample length. It uses counts of 0 and 2 with code 00, where a design with no clamp would give 1 or 3 cycles. It uses a count of 0 with code 01, where a design that clamps every code would give 16 instead of 4. It uses the largest count with code 11, where a counter that is too narrow would wrap, and channel 31, where a mistake in indexing the select word would pick the wrong setup. It also checks both extremes of the compare setting. It sends starts in the middle of a conversion and changes the settings in the middle of a conversion. A design that restarted on a start, or read live settings, would show wrong phase lengths or an extra done pulse.

// File: rtl/adc_pt_pkg.sv
package adc_pt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SAMP = 2'd1,
    PH_COMP = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  // shift amount for the 2-bit scaling code: x1, x4, x8, x16
  function automatic logic [2:0] mul_shift(input logic [1:0] code);
    case (code)
      2'b00:   mul_shift = 3'd0;
      2'b01:   mul_shift = 3'd2;
      2'b10:   mul_shift = 3'd3;
      default: mul_shift = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/adc_pt_slen.sv
module adc_pt_slen #(
  parameter int ST_W   = 6,
  parameter int CNT_W  = 11,
  parameter int MIN_ST = 3
) (
  input  logic [ST_W-1:0]  st_cnt,
  input  logic [1:0]       st_mul,
  output logic [CNT_W-1:0] len
);
  import adc_pt_pkg::*;

  logic [ST_W-1:0]  st_eff;
  logic [CNT_W-1:0] base;

  always_comb begin
    // unscaled setting needs a minimum count; scaled ones are used as given
    if (st_mul == 2'b00 && st_cnt < ST_W'(MIN_ST)) st_eff = ST_W'(MIN_ST);
    else                                          st_eff = st_cnt;
    base = CNT_W'(st_eff) + CNT_W'(1);
    len  = base << mul_shift(st_mul);
  end
endmodule

// File: rtl/adc_pt_clen.sv
module adc_pt_clen #(
  parameter int CT_W  = 3,
  parameter int CNT_W = 11
) (
  input  logic [CT_W-1:0]  ct,
  output logic [CNT_W-1:0] len
);
  logic [CNT_W-1:0] n;

  always_comb begin
    n   = CNT_W'(ct) + CNT_W'(1);
    len = (n << 3) + (n << 1) + CNT_W'(4);  // n*10 + 4
  end
endmodule

// File: rtl/adc_pt_seq.sv
module adc_pt_seq #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] slen,
  input  logic [CNT_W-1:0] clen,
  output logic             busy,
  output logic             sample_ph,
  output logic             compare_ph,
  output logic             done
);
  import adc_pt_pkg::*;

  phase_e           state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [CNT_W-1:0] clen_q, clen_n;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    clen_n  = clen_q;
    case (state)
      PH_IDLE: if (start) begin
        state_n = PH_SAMP;
        cnt_n   = slen - CNT_W'(1);
        clen_n  = clen;
      end
      PH_SAMP: if (cnt == '0) begin
        state_n = PH_COMP;
        cnt_n   = clen_q - CNT_W'(1);
      end else begin
        cnt_n = cnt - CNT_W'(1);
      end
      PH_COMP: if (cnt == '0) state_n = PH_DONE;
               else           cnt_n   = cnt - CNT_W'(1);
      default: state_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= PH_IDLE;
      cnt        <= '0;
      clen_q     <= '0;
      busy       <= 1'b0;
      sample_ph  <= 1'b0;
      compare_ph <= 1'b0;
      done       <= 1'b0;
    end else begin
      state      <= state_n;
      cnt        <= cnt_n;
      clen_q     <= clen_n;
      busy       <= (state_n != PH_IDLE);
      sample_ph  <= (state_n == PH_SAMP);
      compare_ph <= (state_n == PH_COMP);
      done       <= (state_n == PH_DONE);
    end
  end

  // R9: phases never overlap
  a_r9_phase_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sample_ph, compare_ph, done}));
  // R6: done follows the compare phase
  a_r6_done_after_cmp: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(compare_ph));
  // R6: done is a single-cycle pulse and busy drops after it
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));
  // R7: a sample phase starts only from idle with a request
  a_r7_start_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_ph) |-> $past(!busy && start));
  // R5: the compare phase never hands back to sampling
  a_r5_cmp_then_done: assert property (@(posedge clk) disable iff (rst)
    $fell(compare_ph) |-> done);
  // R6: busy covers every phase
  a_r6_busy_cover: assert property (@(posedge clk) disable iff (rst)
    (sample_ph || compare_ph || done) |-> busy);
endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int ST_W   = 6,
  parameter int CT_W   = 3,
  parameter int CH_W   = 5,
  parameter int MIN_ST = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [CH_W-1:0]      chan,
  input  logic [ST_W-1:0]      st0_cnt,
  input  logic [1:0]           st0_mul,
  input  logic [ST_W-1:0]      st1_cnt,
  input  logic [1:0]           st1_mul,
  input  logic [(1<<CH_W)-1:0] ch_setup_sel,
  input  logic [CT_W-1:0]      cmp_ct,
  output logic                 busy,
  output logic                 sample_ph,
  output logic                 compare_ph,
  output logic                 done
);
  localparam int NSET  = 2;
  localparam int S_MAX = (1 << ST_W) * 16;
  localparam int CNT_W = $clog2(S_MAX + 1);

  logic [ST_W-1:0]  set_cnt [NSET];
  logic [1:0]       set_mul [NSET];
  logic [CNT_W-1:0] set_len [NSET];
  logic [CNT_W-1:0] slen, clen;
  logic             sel;

  assign set_cnt[0] = st0_cnt;
  assign set_mul[0] = st0_mul;
  assign set_cnt[1] = st1_cnt;
  assign set_mul[1] = st1_mul;

  for (genvar g = 0; g < NSET; g++) begin : g_setup
    adc_pt_slen #(.ST_W(ST_W), .CNT_W(CNT_W), .MIN_ST(MIN_ST)) u_slen (
      .st_cnt (set_cnt[g]),
      .st_mul (set_mul[g]),
      .len    (set_len[g])
    );
  end

  assign sel  = ch_setup_sel[chan];
  assign slen = set_len[sel];

  adc_pt_clen #(.CT_W(CT_W), .CNT_W(CNT_W)) u_clen (
    .ct  (cmp_ct),
    .len (clen)
  );

  adc_pt_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .slen       (slen),
    .clen       (clen),
    .busy       (busy),
    .sample_ph  (sample_ph),
    .compare_ph (compare_ph),
    .done       (done)
  );

  // R3: the chosen sample length never drops under the clamped minimum
  a_r3_min_len: assert property (@(posedge clk) disable iff (rst)
    slen >= CNT_W'(MIN_ST + 1));
endmodule

// File: tb/sim_adc_phase_timer.sv
`timescale 1ns/1ps
module sim_adc_phase_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  chan = '0;
  logic [5:0]  st0_cnt = '0, st1_cnt = '0;
  logic [1:0]  st0_mul = '0, st1_mul = '0;
  logic [31:0] ch_setup_sel = '0;
  logic [2:0]  cmp_ct = '0;
  logic        busy, sample_ph, compare_ph, done;

  int n_chk = 0, n_bad = 0, n_push = 0, n_done = 0;
  int exp_q[$];
  int scnt = 0, ccnt = 0;

  always #2 clk = ~clk;

  adc_phase_timer u0 (
    .clk(clk), .rst(rst), .start(start), .chan(chan),
    .st0_cnt(st0_cnt), .st0_mul(st0_mul), .st1_cnt(st1_cnt), .st1_mul(st1_mul),
    .ch_setup_sel(ch_setup_sel), .cmp_ct(cmp_ct),
    .busy(busy), .sample_ph(sample_ph), .compare_ph(compare_ph), .done(done));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int s_len(input int st, input int code);
    int m, e;
    m = (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 16;
    e = (code == 0 && st < 3) ? 3 : st;
    return (e + 1) * m;
  endfunction

  function automatic int c_len(input int ct);
    return (ct + 1) * 10 + 4;
  endfunction

  // monitor: measures phase lengths and compares against the queue
  always @(negedge clk) begin
    if (!rst) begin
      check("R9 phase exclusive", int'(sample_ph) + int'(compare_ph) + int'(done) <= 1, 1);
      if (sample_ph) scnt++;
      if (compare_ph) ccnt++;
      if (done) begin
        int e;
        n_done++;
        check("R6 busy in done cycle", busy, 1);
        if (exp_q.size() == 0) check("R7 no extra conversion", 1, 0);
        else begin
          e = exp_q.pop_front();
          check("R2 sample length", scnt, e / 1000);
          check("R5 compare length", ccnt, e % 1000);
        end
        scnt = 0;
        ccnt = 0;
      end
    end
  end

  // driver: requests one conversion and pushes its expected lengths
  task automatic run(input int ch, input int es, input int ec, input bit poke);
    while (busy) @(negedge clk);
    chan  = 5'(ch);
    start = 1'b1;
    exp_q.push_back(es * 1000 + ec);
    n_push++;
    @(negedge clk);
    start = 1'b0;
    check("R2 sample starts next cycle", sample_ph, 1);
    check("R6 busy after accept", busy, 1);
    if (poke) begin
      // R7 / R8: request again and disturb settings mid-conversion
      repeat (2) @(negedge clk);
      start = 1'b1; chan = 5'(ch ^ 1);
      st0_cnt = 6'd50; st1_cnt = 6'd50; st0_mul = 2'd3; st1_mul = 2'd3;
      ch_setup_sel = ~ch_setup_sel; cmp_ct = 3'd6;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check("R6 busy low after done", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 sample in reset", sample_ph, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 compare after reset", compare_ph, 0);
    check("R1 done after reset", done, 0);

    // R2/R5 nominal: ST=7 x1 -> 8, CT=1 -> 24 (R4 setup 0)
    st0_cnt = 6'd7; st0_mul = 2'd0; cmp_ct = 3'd1;
    st1_cnt = 6'd19; st1_mul = 2'd1;
    ch_setup_sel = 32'h8000_0004;
    run(0, 8, 24, 0);
    // R4 channel 2 selects setup 1: 20*4 = 80
    run(2, s_len(19, 1), c_len(1), 0);
    // R4 channel 31 on setup 1, CT=7 -> 84
    cmp_ct = 3'd7;
    run(31, 80, c_len(7), 0);
    // R3 clamp with x1
    cmp_ct = 3'd0;
    st0_cnt = 6'd0; run(1, s_len(0, 0), c_len(0), 0);
    st0_cnt = 6'd2; run(1, 4, 14, 0);
    st0_cnt = 6'd3; run(1, 4, 14, 0);
    // R3 no clamp when scaled
    st0_cnt = 6'd0; st0_mul = 2'd1; run(3, 4, 14, 0);
    st0_mul = 2'd2; st0_cnt = 6'd5; run(3, s_len(5, 2), 14, 0);
    // R2 largest: 64*16 = 1024
    st0_cnt = 6'd63; st0_mul = 2'd3; cmp_ct = 3'd4; run(5, 1024, c_len(4), 0);
    // R7/R8: restart request and settings change during conversion
    st0_cnt = 6'd9; st0_mul = 2'd0; st1_cnt = 6'd1; st1_mul = 2'd0;
    ch_setup_sel = 32'h0000_0000; cmp_ct = 3'd2;
    run(4, 10, c_len(2), 1);
    repeat (3) @(negedge clk);
    check("R7 no extra conversion count", n_done, n_push);
    check("R7 queue drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule